// File: doc/BRIEF.md
# Modular-Exponentiation Engine Control Register File

This block is the software-visible control surface of a public-key exponentiation accelerator. A processor reaches it over a simple 32-bit register bus: single-cycle writes, with reads decoded combinationally from the address. The registers hold the following:

- two start bits, one for the compute step and one for the DMA load;
- a command word that picks the DMA/SRAM mode and says who owns the operand memory;
- the DMA source address and byte count;
- a packed word with the exponent and modulus bit counts;
- an interrupt mask and an interrupt status.

The block turns register writes into single-cycle start pulses for the datapath. It presents every configuration field as a steady output.

The engine reports completion with a one-cycle done pulse. That pulse sets a sticky status bit. Software clears the bit by writing back the value it read, since status is write-one-to-clear. The interrupt line is a registered copy of the masked status. A typical run goes like this: software hands the operand memory to the engine, programs address, length and key sizes, unmasks the done event and sets both start bits. On the interrupt it writes zero to the start register, clears the status and takes the memory back.

Top module: `modexp_csr`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero except the command register, which reads 0x0000_0100 (memory owned by the CPU). All start pulses and the interrupt are low.
- R2: The start register sits at offset 0x000, with bit 0 = compute and bit 1 = DMA. A write that takes a bit from 0 to 1 produces a pulse on the matching start output for exactly the one cycle after the write. The bit then reads back as 1, and the matching run output stays high.
- R3: Writing 1 to a start bit that is already 1 produces no pulse. Writing 0 clears the bit and its run output, which stops the engine. A later 0-to-1 write pulses again.
- R4: The command register sits at offset 0x048. Field [5:4] drives the two-bit DMA mode output, where 2'b11 selects exponentiation SRAM mode. Bit 8 drives the memory-ownership output: 1 means the CPU bus owns the data memory and 0 means the engine owns it. All other bits are not stored and read as 0.
- R5: The DMA source address (offset 0x04C) and the DMA byte length (offset 0x050) are full 32-bit read/write registers, each driving its own output.
- R6: The key-length register sits at offset 0x058. It stores 32 bits, with the exponent bit count in [31:16] and the modulus bit count in [15:0], each driving its own output.
- R7: The interrupt mask sits at offset 0x3F8. Only bit 1 (the done event) is stored, and all other bits read as 0.
- R8: A done pulse from the engine sets bit 1 of the status register at offset 0x3FC. The bit stays set until software clears it.
- R9: A status write with bit 1 set clears the bit, and a write with bit 1 clear leaves it unchanged. If a done pulse and a clearing write arrive in the same cycle, the bit ends up set.
- R10: The interrupt output is registered. In each cycle it equals the AND of status bit 1 and mask bit 1 from the previous cycle.
- R11: Offsets not listed above read as zero, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, decoded from bus_addr |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| calc_start | output | 1 | One-cycle compute start pulse |
| dma_start | output | 1 | One-cycle DMA start pulse |
| calc_run | output | 1 | Compute start bit level |
| dma_run | output | 1 | DMA start bit level |
| dma_mode | output | 2 | DMA/SRAM mode field |
| mem_cpu_own | output | 1 | 1 = CPU owns data memory, 0 = engine owns it |
| dma_src_addr | output | 32 | DMA source base address |
| dma_len | output | 32 | DMA length in bytes |
| exp_bits | output | 16 | Exponent bit count |
| mod_bits | output | 16 | Modulus bit count |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a done pulse from the engine landing in the same clock edge as a software write that clears the status bit. The bench drives eng_done and a status write carrying bit 1 from the same falling edge, so both are sampled on one rising edge. It then reads the status back to confirm the set won. A second hard case is the one-cycle lag of the interrupt behind the status and the mask. The bench samples irq on the falling edge right after the status or mask changes, and again one cycle later, so a combinational interrupt path would show up.

// File: rtl/modexp_csr_pkg.sv
// Package: register offsets, bit positions and the register-select type
// shared by the decoder, the top module and the checker.
package modexp_csr_pkg;

    // Byte offsets of the registers
    localparam int unsigned OFF_START  = 32'h000;
    localparam int unsigned OFF_CMD    = 32'h048;
    localparam int unsigned OFF_SRC    = 32'h04C;
    localparam int unsigned OFF_LEN    = 32'h050;
    localparam int unsigned OFF_KEYLEN = 32'h058;
    localparam int unsigned OFF_MASK   = 32'h3F8;
    localparam int unsigned OFF_STS    = 32'h3FC;

    // Field positions
    localparam int unsigned NUM_START   = 2;   // bit 0 compute, bit 1 DMA
    localparam int unsigned CMD_MODE_LO = 4;
    localparam int unsigned CMD_MODE_W  = 2;
    localparam int unsigned CMD_CPU_BIT = 8;
    localparam int unsigned EVT_DONE    = 1;

    typedef enum logic [2:0] {
        RID_NONE,
        RID_START,
        RID_CMD,
        RID_SRC,
        RID_LEN,
        RID_KEYLEN,
        RID_MASK,
        RID_STS
    } reg_id_e;

endpackage

// File: rtl/csr_addr_dec.sv
// Module: csr_addr_dec
// Maps a bus byte offset onto a register identifier. Purely combinational.
// Assumes full-offset matching, so any offset not in the map yields RID_NONE.
module csr_addr_dec
    import modexp_csr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           rid
);

    // Compare the offset against each mapped register
    always_comb begin
        if      (addr == ADDR_W'(OFF_START))  rid = RID_START;
        else if (addr == ADDR_W'(OFF_CMD))    rid = RID_CMD;
        else if (addr == ADDR_W'(OFF_SRC))    rid = RID_SRC;
        else if (addr == ADDR_W'(OFF_LEN))    rid = RID_LEN;
        else if (addr == ADDR_W'(OFF_KEYLEN)) rid = RID_KEYLEN;
        else if (addr == ADDR_W'(OFF_MASK))   rid = RID_MASK;
        else if (addr == ADDR_W'(OFF_STS))    rid = RID_STS;
        else                                  rid = RID_NONE;
    end

endmodule

// File: rtl/start_ctrl.sv
// Module: start_ctrl
// Holds N start bits. Each bit emits a one-cycle pulse when a write takes it
// from 0 to 1. Assumes wr_en is high for exactly the cycle of a start write.
module start_ctrl #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] run_q,
    output logic [N-1:0] pulse_q
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic run_b;
        logic pulse_b;

        // Level bit follows writes; the pulse fires only on a rising write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                run_b   <= 1'b0;
                pulse_b <= 1'b0;
            end else begin
                pulse_b <= wr_en && wdata[g] && !run_b;
                if (wr_en) run_b <= wdata[g];
            end
        end

        assign run_q[g]   = run_b;
        assign pulse_q[g] = pulse_b;
    end

endmodule

// File: rtl/irq_ctrl.sv
// Module: irq_ctrl
// Sticky done-event status (write-one-to-clear), its mask bit and a registered
// interrupt line. Assumes evt is a single-cycle pulse. A set beats a clear.
module irq_ctrl #(
    parameter int DATA_W  = 32,
    parameter int EVT_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic              sts_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt,
    output logic              mask_q,
    output logic              sts_q,
    output logic              irq_q
);

    // Mask bit: plain read/write of the event bit only
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= 1'b0;
        else if (mask_wr) mask_q <= wdata[EVT_BIT];
    end

    // Status bit: set by event, cleared by writing one, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)                          sts_q <= 1'b0;
        else if (evt)                        sts_q <= 1'b1;
        else if (sts_wr && wdata[EVT_BIT])   sts_q <= 1'b0;
    end

    // Interrupt line: registered masked status
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= sts_q && mask_q;
    end

endmodule

// File: rtl/modexp_csr.sv
// Module: modexp_csr
// Control/status register file of the exponentiation accelerator. Decodes a
// simple 32-bit register bus, holds configuration registers, drives start
// pulses and a level interrupt. Assumes single-cycle write strobes and
// combinational reads; DATA_W must be even so the key word splits in halves.
module modexp_csr
    import modexp_csr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int KEY_W  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_done,
    output logic              calc_start,
    output logic              dma_start,
    output logic              calc_run,
    output logic              dma_run,
    output logic [CMD_MODE_W-1:0] dma_mode,
    output logic              mem_cpu_own,
    output logic [DATA_W-1:0] dma_src_addr,
    output logic [DATA_W-1:0] dma_len,
    output logic [KEY_W-1:0]  exp_bits,
    output logic [KEY_W-1:0]  mod_bits,
    output logic              irq
);

    localparam int CMD_MODE_HI = CMD_MODE_LO + CMD_MODE_W - 1;

    reg_id_e               rid;
    logic                  wr_act;
    logic [NUM_START-1:0]  run_vec;
    logic [NUM_START-1:0]  pulse_vec;
    logic [CMD_MODE_W-1:0] mode_q;
    logic                  cpu_own_q;
    logic [DATA_W-1:0]     src_q;
    logic [DATA_W-1:0]     len_q;
    logic [DATA_W-1:0]     key_q;
    logic                  evt_mask;
    logic                  evt_sts;

    csr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .rid  (rid)
    );

    assign wr_act = bus_sel && bus_wr;

    start_ctrl #(.N(NUM_START)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_act && (rid == RID_START)),
        .wdata   (bus_wdata[NUM_START-1:0]),
        .run_q   (run_vec),
        .pulse_q (pulse_vec)
    );

    irq_ctrl #(.DATA_W(DATA_W), .EVT_BIT(EVT_DONE)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (wr_act && (rid == RID_MASK)),
        .sts_wr  (wr_act && (rid == RID_STS)),
        .wdata   (bus_wdata),
        .evt     (eng_done),
        .mask_q  (evt_mask),
        .sts_q   (evt_sts),
        .irq_q   (irq)
    );

    // Command register: mode field and memory-ownership bit; CPU owns at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            cpu_own_q <= 1'b1;
        end else if (wr_act && rid == RID_CMD) begin
            mode_q    <= bus_wdata[CMD_MODE_HI:CMD_MODE_LO];
            cpu_own_q <= bus_wdata[CMD_CPU_BIT];
        end
    end

    // DMA address, DMA length and packed key-length registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            len_q <= '0;
            key_q <= '0;
        end else if (wr_act) begin
            if (rid == RID_SRC)    src_q <= bus_wdata;
            if (rid == RID_LEN)    len_q <= bus_wdata;
            if (rid == RID_KEYLEN) key_q <= bus_wdata;
        end
    end

    // Read mux: unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        unique case (rid)
            RID_START:  bus_rdata[NUM_START-1:0] = run_vec;
            RID_CMD: begin
                bus_rdata[CMD_MODE_HI:CMD_MODE_LO] = mode_q;
                bus_rdata[CMD_CPU_BIT]             = cpu_own_q;
            end
            RID_SRC:    bus_rdata = src_q;
            RID_LEN:    bus_rdata = len_q;
            RID_KEYLEN: bus_rdata = key_q;
            RID_MASK:   bus_rdata[EVT_DONE] = evt_mask;
            RID_STS:    bus_rdata[EVT_DONE] = evt_sts;
            default:    bus_rdata = '0;
        endcase
    end

    // Output fields
    assign calc_start   = pulse_vec[0];
    assign dma_start    = pulse_vec[1];
    assign calc_run     = run_vec[0];
    assign dma_run      = run_vec[1];
    assign dma_mode     = mode_q;
    assign mem_cpu_own  = cpu_own_q;
    assign dma_src_addr = src_q;
    assign dma_len      = len_q;
    assign exp_bits     = key_q[DATA_W-1:KEY_W];
    assign mod_bits     = key_q[KEY_W-1:0];

endmodule

// File: rtl/modexp_csr_chk.sv
// Module: modexp_csr_chk
// Property checker for modexp_csr, bound into every instance of it.
// Assumes sts and mask are the top module's internal status and mask bits.
module modexp_csr_chk
    import modexp_csr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              eng_done,
    input logic              calc_start,
    input logic              dma_start,
    input logic              irq,
    input logic              sts,
    input logic              mask
);

    logic past_ok;
    logic mapped;
    logic start_wr;
    logic sts_clr;

    // Marks cycles whose previous cycle was already out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign mapped = (bus_addr == ADDR_W'(OFF_START))  || (bus_addr == ADDR_W'(OFF_CMD))  ||
                    (bus_addr == ADDR_W'(OFF_SRC))    || (bus_addr == ADDR_W'(OFF_LEN))  ||
                    (bus_addr == ADDR_W'(OFF_KEYLEN)) || (bus_addr == ADDR_W'(OFF_MASK)) ||
                    (bus_addr == ADDR_W'(OFF_STS));
    assign start_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_START));
    assign sts_clr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_STS)) && bus_wdata[EVT_DONE];

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!irq && !calc_start && !dma_start)); // R1
    AST_CALC_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) calc_start |=> !calc_start); // R2
    AST_DMA_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) dma_start |=> !dma_start); // R2
    AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (past_ok && (calc_start || dma_start)) |-> $past(start_wr)); // R3
    AST_DONE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n) eng_done |=> sts); // R8
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (sts && !sts_clr) |=> sts); // R9
    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) past_ok |-> (irq == $past(sts && mask))); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !mapped |-> (bus_rdata == '0)); // R11

endmodule

bind modexp_csr modexp_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .eng_done   (eng_done),
    .calc_start (calc_start),
    .dma_start  (dma_start),
    .irq        (irq),
    .sts        (evt_sts),
    .mask       (evt_mask)
);

// File: tb/sim_modexp_csr.sv
// Bench: sim_modexp_csr
// Directed scenarios, one task each; every task checks its own results.
module sim_modexp_csr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_done = 1'b0;
    logic        calc_start, dma_start, calc_run, dma_run;
    logic [1:0]  dma_mode;
    logic        mem_cpu_own;
    logic [31:0] dma_src_addr, dma_len;
    logic [15:0] exp_bits, mod_bits;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    localparam logic [11:0] A_START = 12'h000, A_CMD = 12'h048, A_SRC = 12'h04C,
                            A_LEN = 12'h050, A_KEY = 12'h058, A_MASK = 12'h3F8,
                            A_STS = 12'h3FC;

    always #10 clk = ~clk;

    modexp_csr u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_done(eng_done), .calc_start(calc_start), .dma_start(dma_start),
        .calc_run(calc_run), .dma_run(dma_run), .dma_mode(dma_mode),
        .mem_cpu_own(mem_cpu_own), .dma_src_addr(dma_src_addr), .dma_len(dma_len),
        .exp_bits(exp_bits), .mod_bits(mod_bits), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Write; returns on the falling edge right after the capturing rising edge
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1", "irq", {31'b0, irq}, 32'h0);
        check("R1", "pulses", {30'b0, calc_start, dma_start}, 32'h0);
        bus_read(A_CMD, d);   check("R1", "cmd reset", d, 32'h0000_0100);
        check("R1", "mem_cpu_own", {31'b0, mem_cpu_own}, 32'h1);
        bus_read(A_START, d); check("R1", "start reset", d, 32'h0);
        bus_read(A_SRC, d);   check("R1", "src reset", d, 32'h0);
        bus_read(A_LEN, d);   check("R1", "len reset", d, 32'h0);
        bus_read(A_KEY, d);   check("R1", "key reset", d, 32'h0);
        bus_read(A_MASK, d);  check("R1", "mask reset", d, 32'h0);
        bus_read(A_STS, d);   check("R1", "sts reset", d, 32'h0);
    endtask

    task automatic t_start;
        logic [31:0] d;
        bus_write(A_START, 32'h1);
        check("R2", "calc pulse", {31'b0, calc_start}, 32'h1);
        check("R2", "no dma pulse", {31'b0, dma_start}, 32'h0);
        @(negedge clk);
        check("R2", "calc pulse width", {31'b0, calc_start}, 32'h0);
        check("R2", "calc_run", {31'b0, calc_run}, 32'h1);
        bus_write(A_START, 32'h3);
        check("R3", "calc no repulse", {31'b0, calc_start}, 32'h0);
        check("R2", "dma pulse", {31'b0, dma_start}, 32'h1);
        bus_read(A_START, d); check("R2", "start readback", d, 32'h3);
        bus_write(A_START, 32'h3);
        check("R3", "repeat write no pulses", {30'b0, calc_start, dma_start}, 32'h0);
        bus_write(A_START, 32'h0);
        check("R3", "stop runs", {30'b0, calc_run, dma_run}, 32'h0);
        bus_read(A_START, d); check("R3", "stop readback", d, 32'h0);
        bus_write(A_START, 32'h2);
        check("R3", "restart dma pulse", {31'b0, dma_start}, 32'h1);
        bus_write(A_START, 32'h0);
    endtask

    task automatic t_cmd;
        logic [31:0] d;
        bus_write(A_CMD, 32'hFFFF_FFFF);
        bus_read(A_CMD, d); check("R4", "cmd masked readback", d, 32'h0000_0130);
        check("R4", "mode", {30'b0, dma_mode}, 32'h3);
        bus_write(A_CMD, 32'h0000_0030);
        check("R4", "engine owns memory", {31'b0, mem_cpu_own}, 32'h0);
        check("R4", "mode kept", {30'b0, dma_mode}, 32'h3);
        bus_write(A_CMD, 32'h0000_0100);
        check("R4", "cpu owns memory", {31'b0, mem_cpu_own}, 32'h1);
        check("R4", "mode cleared", {30'b0, dma_mode}, 32'h0);
    endtask

    task automatic t_cfg;
        logic [31:0] d;
        bus_write(A_SRC, 32'hA5A5_0004);
        bus_write(A_LEN, 32'h0000_1800);
        bus_read(A_SRC, d); check("R5", "src readback", d, 32'hA5A5_0004);
        bus_read(A_LEN, d); check("R5", "len readback", d, 32'h0000_1800);
        check("R5", "src out", dma_src_addr, 32'hA5A5_0004);
        check("R5", "len out", dma_len, 32'h0000_1800);
        bus_write(A_KEY, (32'd17 << 16) | 32'd2048);
        check("R6", "exp bits", {16'b0, exp_bits}, 32'd17);
        check("R6", "mod bits", {16'b0, mod_bits}, 32'd2048);
        bus_write(A_KEY, 32'hFFFF_0001);
        bus_read(A_KEY, d); check("R6", "key readback", d, 32'hFFFF_0001);
        check("R6", "exp bits max", {16'b0, exp_bits}, 32'h0000_FFFF);
        check("R6", "mod bits one", {16'b0, mod_bits}, 32'h1);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        bus_write(A_MASK, 32'h0);
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        bus_read(A_STS, d); check("R8", "status set", d, 32'h2);
        @(negedge clk); check("R10", "masked irq low", {31'b0, irq}, 32'h0);
        bus_write(A_MASK, 32'hFFFF_FFFF);
        check("R10", "irq one cycle late", {31'b0, irq}, 32'h0);
        @(negedge clk); check("R10", "irq raised", {31'b0, irq}, 32'h1);
        bus_read(A_MASK, d); check("R7", "mask only bit1", d, 32'h2);
        bus_write(A_STS, 32'hFFFF_FFFD);
        bus_read(A_STS, d); check("R9", "bit1 clear keeps status", d, 32'h2);
        bus_write(A_STS, 32'h2);
        check("R10", "irq held one cycle", {31'b0, irq}, 32'h1);
        bus_read(A_STS, d); check("R9", "w1c clears", d, 32'h0);
        check("R10", "irq dropped", {31'b0, irq}, 32'h0);
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        check("R10", "irq after done lag", {31'b0, irq}, 32'h0);
        @(negedge clk); check("R10", "irq after done", {31'b0, irq}, 32'h1);
        bus_write(A_STS, 32'h2);
    endtask

    task automatic t_setwin;
        logic [31:0] d;
        @(negedge clk);
        eng_done = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STS; bus_wdata = 32'h2;
        @(negedge clk);
        eng_done = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        bus_read(A_STS, d); check("R9", "set wins over clear", d, 32'h2);
        bus_write(A_STS, 32'h2);
        bus_read(A_STS, d); check("R9", "cleared after", d, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_write(12'h054, 32'hFFFF_FFFF);
        bus_write(12'h3F4, 32'hFFFF_FFFF);
        bus_read(12'h004, d); check("R11", "unmapped 0x004 reads 0", d, 32'h0);
        bus_read(12'h054, d); check("R11", "unmapped 0x054 reads 0", d, 32'h0);
        bus_read(A_SRC, d);   check("R11", "src untouched", d, 32'hA5A5_0004);
        bus_read(A_KEY, d);   check("R11", "key untouched", d, 32'hFFFF_0001);
        bus_read(A_START, d); check("R11", "start untouched", d, 32'h0);
        check("R11", "no pulses", {30'b0, calc_start, dma_start}, 32'h0);
        check("R11", "irq untouched", {31'b0, irq}, 32'h0);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_start;
        t_cmd;
        t_cfg;
        t_irq;
        t_setwin;
        t_unmapped;
        finished = 1'b1;
        summary;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary;
        end
    end

endmodule